// File: doc/BRIEF.md
# Table-Routed Stream Router Cell

A five-port switching node for a hierarchical on-chip network. Four local inputs and one global (default) input each carry a stream with valid/ready handshakes. A fixed routing map, set by parameter, gives every input a mask of outputs. An input with several bits in its mask broadcasts each word to all of them in the same cycle. Every output has a small FIFO, so a word accepted on an edge is visible at the output one cycle later.

A decision unit builds the candidate list each cycle. It runs either a per-output arbiter or a single arbiter for the whole switch. Two run-time inputs set the switch. The first chooses parallel mode, where non-conflicting transfers proceed together, or single-path mode, where at most one transfer proceeds per cycle. The second chooses fixed-priority or round-robin arbitration. A broadcast proceeds only if every target has room and every target grants it. If not, it waits with nothing sent.

Top module: `stream_router_cell`

## Requirements
- R1: After reset, all `out_valid_o` and all `in_ready_o` bits are 0 while no input is valid.
- R2: Words go only to the outputs in the default map: input 0 to output 0, input 1 to output 0, input 2 to outputs 1 and 2, input 3 to output 2, input 4 to outputs 3 and 4. Each output delivers its words in the order they were accepted, with none lost or duplicated. An input's ready is never high while its valid is low.
- R3: A word accepted on a clock edge sets the target `out_valid_o` bit from the following cycle on: one cycle per hop.
- R4: A broadcast input is accepted only in a cycle where all of its target outputs take the word. While any target FIFO is full, its ready stays 0 and no target receives anything from it.
- R5: With `arb_policy_i`=0 (fixed), the lowest-numbered competing input wins an output.
- R6: With `arb_policy_i`=1 (round robin), after input i is granted, the search for the next grant starts at input i+1 (wrapping). Two inputs that keep contending alternate.
- R7: With `switch_mode_i`=0 (parallel), all non-conflicting transfers happen in the same cycle. Inputs 0, 2 and 4 valid together are all accepted at once.
- R8: With `switch_mode_i`=1 (single path), at most one input is accepted per cycle.
- R9: Each output FIFO holds 4 words. While it is full, every input routed to it sees ready 0.
- R10: While an output is valid and not ready, it stays valid and its data does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| switch_mode_i | input | 1 | 0 parallel, 1 single path |
| arb_policy_i | input | 1 | 0 fixed priority, 1 round robin |
| in_valid_i | input | 5 | Input valid, bit 4 is the global input |
| in_ready_o | output | 5 | Input ready |
| in_data_i | input | 80 | Input words, port i in bits [16i+15:16i] |
| out_valid_o | output | 5 | Output valid |
| out_ready_i | input | 5 | Output ready |
| out_data_o | output | 80 | Output words, port o in bits [16o+15:16o] |

## Verification
The hardest case is a broadcast held back by one full target while its other target sits empty. From the ports this needs a stalled sink and a second input that has already filled the shared FIFO. The bench holds output 2 not ready and streams input 3 until it is refused. It then raises input 2 and checks that output 1 stays empty. Finally it releases output 2 and checks that the broadcast goes out as one transfer once room appears. Round-robin fairness is checked by holding two contenders valid and requiring the grant to alternate every cycle, in both switch modes.

// File: rtl/stream_router_pkg.sv
package stream_router_pkg;
  localparam int unsigned ROUTER_PORTS = 5;

  typedef enum logic {
    SW_PARALLEL = 1'b0,
    SW_SINGLE   = 1'b1
  } sw_mode_e;

  typedef enum logic {
    ARB_FIXED = 1'b0,
    ARB_ROUND = 1'b1
  } arb_policy_e;
endpackage

// File: rtl/route_arb.sv
module route_arb #(
  parameter int N = 5,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req_i,
  input  logic [IW-1:0] base_i,
  output logic [N-1:0]  gnt_o,
  output logic [IW-1:0] idx_o
);
  // first requester found scanning upward from base, wrapping
  always_comb begin
    int  pos;
    logic hit;
    gnt_o = '0;
    idx_o = '0;
    hit   = 1'b0;
    for (int k = 0; k < N; k++) begin
      pos = int'(base_i) + k;
      if (pos >= N) pos = pos - N;
      if (!hit && req_i[pos]) begin
        gnt_o[pos] = 1'b1;
        idx_o      = IW'(pos);
        hit        = 1'b1;
      end
    end
  end
endmodule

// File: rtl/stream_fifo.sv
module stream_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 4,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] wdata_i,
  input  logic         pop_i,
  output logic [W-1:0] rdata_o,
  output logic         full_o,
  output logic         empty_o
);
  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] wr_ptr_q, rd_ptr_q;
  logic [CW-1:0] count_q;
  logic          do_push, do_pop;

  assign full_o  = (count_q == CW'(DEPTH));
  assign empty_o = (count_q == '0);
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;
  assign rdata_o = mem_q[rd_ptr_q];

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wr_ptr_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
    end else begin
      if (do_push) wr_ptr_q <= bump(wr_ptr_q);
      if (do_pop)  rd_ptr_q <= bump(rd_ptr_q);
      if (do_push && !do_pop)      count_q <= count_q + 1'b1;
      else if (do_pop && !do_push) count_q <= count_q - 1'b1;
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> !full_o); // R9
  AST_HOLD_HEAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!empty_o && !pop_i) |=> (!empty_o && $stable(rdata_o))); // R10
endmodule

// File: rtl/route_decide.sv
module route_decide #(
  parameter int N = 5,
  parameter logic [N*N-1:0] ROUTE_MAP = '0,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         mode_i,
  input  logic         policy_i,
  input  logic [N-1:0] valid_i,
  input  logic [N-1:0] full_i,
  output logic [N-1:0] grant_o,
  output logic [N-1:0] wr_en_o,
  output logic [N-1:0] src_o [N]
);
  import stream_router_pkg::*;

  logic [N-1:0]  tgt      [N];
  logic [N-1:0]  req_col  [N];
  logic [N-1:0]  col_gnt  [N];
  logic [IW-1:0] col_idx  [N];
  logic [IW-1:0] out_ptr_q[N];
  logic [IW-1:0] g_ptr_q, g_idx;
  logic [N-1:0]  elig, par_win, g_gnt;
  logic          rr_on;

  assign rr_on = (arb_policy_e'(policy_i) == ARB_ROUND);

  function automatic logic [IW-1:0] next_ptr(input logic [IW-1:0] p);
    return (p == IW'(N - 1)) ? '0 : p + 1'b1;
  endfunction

  for (genvar i = 0; i < N; i++) begin : g_in
    assign tgt[i]  = ROUTE_MAP[i*N +: N];
    // candidate: valid, routed somewhere, and every target has room
    assign elig[i] = valid_i[i] && (tgt[i] != '0) && ((tgt[i] & full_i) == '0);
  end

  for (genvar o = 0; o < N; o++) begin : g_out
    for (genvar i = 0; i < N; i++) begin : g_req
      assign req_col[o][i] = elig[i] && tgt[i][o];
      assign src_o[o][i]   = grant_o[i] && tgt[i][o];
    end
    route_arb #(.N(N)) u_col_arb (
      .req_i (req_col[o]),
      .base_i(rr_on ? out_ptr_q[o] : '0),
      .gnt_o (col_gnt[o]),
      .idx_o (col_idx[o])
    );
    assign wr_en_o[o] = |src_o[o];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) out_ptr_q[o] <= '0;
      else if (wr_en_o[o])
        out_ptr_q[o] <= next_ptr(sw_mode_e'(mode_i) == SW_SINGLE ? g_idx : col_idx[o]);
    end

    AST_ONE_WRITER: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0(src_o[o])); // R7
  end

  route_arb #(.N(N)) u_glb_arb (
    .req_i (elig),
    .base_i(rr_on ? g_ptr_q : '0),
    .gnt_o (g_gnt),
    .idx_o (g_idx)
  );

  // parallel: an input proceeds only if it wins every output it targets
  always_comb begin
    for (int i = 0; i < N; i++) begin
      par_win[i] = elig[i];
      for (int o = 0; o < N; o++)
        if (tgt[i][o] && !col_gnt[o][i]) par_win[i] = 1'b0;
    end
  end

  assign grant_o = (sw_mode_e'(mode_i) == SW_SINGLE) ? g_gnt : par_win;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) g_ptr_q <= '0;
    else if ((sw_mode_e'(mode_i) == SW_SINGLE) && (g_gnt != '0)) g_ptr_q <= next_ptr(g_idx);
  end

  AST_SINGLE_PATH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_i |-> $onehot0(grant_o)); // R8
  AST_GRANT_NEEDS_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grant_o & ~valid_i) == '0); // R2
  AST_NO_GRANT_INTO_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_o & full_i) == '0); // R9
endmodule

// File: rtl/stream_router_cell.sv
module stream_router_cell #(
  parameter int DATA_W     = 16,
  parameter int FIFO_DEPTH = 4,
  parameter int NP         = stream_router_pkg::ROUTER_PORTS,
  parameter logic [NP*NP-1:0] ROUTE_MAP =
    {5'b11000, 5'b00100, 5'b00110, 5'b00001, 5'b00001}
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               switch_mode_i,
  input  logic               arb_policy_i,
  input  logic [NP-1:0]      in_valid_i,
  output logic [NP-1:0]      in_ready_o,
  input  logic [NP*DATA_W-1:0] in_data_i,
  output logic [NP-1:0]      out_valid_o,
  input  logic [NP-1:0]      out_ready_i,
  output logic [NP*DATA_W-1:0] out_data_o
);
  logic [NP-1:0]     grant, wr_en, full, empty;
  logic [NP-1:0]     src   [NP];
  logic [DATA_W-1:0] wdata [NP];

  route_decide #(.N(NP), .ROUTE_MAP(ROUTE_MAP)) u_decide (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .mode_i  (switch_mode_i),
    .policy_i(arb_policy_i),
    .valid_i (in_valid_i),
    .full_i  (full),
    .grant_o (grant),
    .wr_en_o (wr_en),
    .src_o   (src)
  );

  assign in_ready_o = grant;

  for (genvar o = 0; o < NP; o++) begin : g_port
    always_comb begin
      wdata[o] = '0;
      for (int i = 0; i < NP; i++)
        if (src[o][i]) wdata[o] = wdata[o] | in_data_i[i*DATA_W +: DATA_W];
    end

    stream_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) u_oq (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .push_i (wr_en[o]),
      .wdata_i(wdata[o]),
      .pop_i  (out_ready_i[o]),
      .rdata_o(out_data_o[o*DATA_W +: DATA_W]),
      .full_o (full[o]),
      .empty_o(empty[o])
    );
    assign out_valid_o[o] = !empty[o];

    AST_ONE_CYCLE_HOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr_en[o] |=> out_valid_o[o]); // R3
    AST_OUT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (out_valid_o[o] && !out_ready_i[o]) |=> out_valid_o[o]); // R10
  end

  for (genvar i = 0; i < NP; i++) begin : g_bcast
    localparam logic [NP-1:0] TGT = ROUTE_MAP[i*NP +: NP];
    AST_BCAST_ATOMIC: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (in_valid_i[i] && in_ready_o[i]) |-> ((wr_en & TGT) == TGT)); // R4
  end
endmodule

// File: tb/tb_stream_router_cell.sv
`timescale 1ns/1ps
module tb_stream_router_cell;
  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic        mode, policy;
  logic [4:0]  in_valid, in_ready, out_valid, out_ready;
  logic [79:0] in_data, out_data;

  int unsigned n_cmp = 0;
  int unsigned n_err = 0;
  logic [15:0] exp_q [5][$];

  always #4 clk_i = ~clk_i;

  stream_router_cell dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .switch_mode_i(mode), .arb_policy_i(policy),
    .in_valid_i(in_valid), .in_ready_o(in_ready), .in_data_i(in_data),
    .out_valid_o(out_valid), .out_ready_i(out_ready), .out_data_o(out_data)
  );

  function automatic logic [4:0] route_of(input int i);
    case (i)
      0, 1:    return 5'b00001;
      2:       return 5'b00110;
      3:       return 5'b00100;
      default: return 5'b11000;
    endcase
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic put(input int i, input logic [15:0] v);
    in_data[i*16 +: 16] = v;
  endtask

  // scoreboard monitor: pops on output handshakes, pushes on input handshakes
  always @(negedge clk_i) begin
    if (rst_ni) begin
      for (int o = 0; o < 5; o++) begin
        if (out_valid[o] && out_ready[o]) begin
          if (exp_q[o].size() == 0) chk(1'b0, "R2 unexpected output word", out_data[o*16 +: 16], 0);
          else begin
            logic [15:0] e;
            e = exp_q[o].pop_front();
            chk(out_data[o*16 +: 16] == e, "R2 output word order", out_data[o*16 +: 16], e);
          end
        end
      end
      for (int i = 0; i < 5; i++) begin
        if (in_valid[i] && in_ready[i]) begin
          logic [4:0] m;
          m = route_of(i);
          for (int o = 0; o < 5; o++)
            if (m[o]) exp_q[o].push_back(in_data[i*16 +: 16]);
        end
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk_i);
    n_err++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
    $finish;
  end

  initial begin
    logic [1:0]  prev;
    logic [4:0]  acc;
    logic [15:0] held;
    int          accepted;
    bit          seen;
    mode = 1'b0; policy = 1'b0; in_valid = '0; in_data = '0; out_ready = '1; rst_ni = 1'b0;
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;
    @(negedge clk_i);
    chk(out_valid == 5'b0, "R1 out_valid after reset", out_valid, 0);
    chk(in_ready == 5'b0, "R1 in_ready idle", in_ready, 0);

    // single word, one-cycle hop
    @(posedge clk_i); #1 in_valid = 5'b00001; put(0, 16'h0A01);
    @(negedge clk_i); chk(in_ready == 5'b00001, "R2 input 0 accepted", in_ready, 5'b00001);
    @(posedge clk_i); #1 in_valid = '0;
    @(negedge clk_i);
    chk(out_valid == 5'b00001, "R3 hop latency", out_valid, 5'b00001);
    chk(out_data[15:0] == 16'h0A01, "R3 hop data", out_data[15:0], 16'h0A01);

    // parallel, non-conflicting, with broadcasts
    @(posedge clk_i); #1 in_valid = 5'b10101; put(0, 16'h0B00); put(2, 16'h0B02); put(4, 16'h0B04);
    @(negedge clk_i); chk(in_ready == 5'b10101, "R7 concurrent accept", in_ready, 5'b10101);
    @(posedge clk_i); #1 in_valid = '0;
    @(negedge clk_i); chk(out_valid == 5'b11111, "R4 broadcast reaches all targets", out_valid, 5'b11111);

    // fixed priority
    for (int k = 0; k < 3; k++) begin
      @(posedge clk_i); #1 in_valid = 5'b00011; put(0, 16'h0C00 + 16'(k)); put(1, 16'h0C10 + 16'(k));
      @(negedge clk_i); chk(in_ready == 5'b00001, "R5 lower index wins", in_ready, 5'b00001);
    end
    @(posedge clk_i); #1 in_valid = 5'b01100; put(2, 16'h0C22); put(3, 16'h0C33);
    @(negedge clk_i); chk(in_ready == 5'b00100, "R5 input 2 over input 3", in_ready, 5'b00100);

    // round robin, parallel mode
    policy = 1'b1;
    prev = '0;
    for (int k = 0; k < 6; k++) begin
      @(posedge clk_i); #1 in_valid = 5'b00011; put(0, 16'h0D00 + 16'(k)); put(1, 16'h0D10 + 16'(k));
      @(negedge clk_i);
      chk($countones(in_ready[1:0]) == 1, "R6 one winner on shared output", in_ready, 0);
      if (k > 0) chk(in_ready[1:0] != prev, "R6 alternation", in_ready[1:0], ~prev);
      prev = in_ready[1:0];
    end
    prev = '0;
    for (int k = 0; k < 4; k++) begin
      @(posedge clk_i); #1 in_valid = 5'b01100; put(2, 16'h0D20 + 16'(k)); put(3, 16'h0D30 + 16'(k));
      @(negedge clk_i);
      if (k > 0) chk(in_ready[3:2] != prev, "R6 alternation with broadcast", in_ready[3:2], ~prev);
      prev = in_ready[3:2];
    end

    // single path
    mode = 1'b1; policy = 1'b0;
    for (int k = 0; k < 3; k++) begin
      @(posedge clk_i); #1 in_valid = 5'b11111;
      for (int i = 0; i < 5; i++) put(i, 16'h0E00 + 16'(i*16 + k));
      @(negedge clk_i); chk(in_ready == 5'b00001, "R8 single path fixed", in_ready, 5'b00001);
    end
    policy = 1'b1;
    acc = '0;
    for (int k = 0; k < 5; k++) begin
      @(posedge clk_i); #1 in_valid = 5'b11111;
      for (int i = 0; i < 5; i++) put(i, 16'h0F00 + 16'(i*16 + k));
      @(negedge clk_i);
      chk($countones(in_ready) == 1, "R8 one transfer per cycle", in_ready, 0);
      acc = acc | in_ready;
    end
    chk(acc == 5'b11111, "R6 single path rotates over all inputs", acc, 5'b11111);

    mode = 1'b0; policy = 1'b0;
    @(posedge clk_i); #1 in_valid = '0;
    repeat (4) @(posedge clk_i);

    // fill output 2 with a stalled sink
    #1 out_ready = 5'b11011;
    accepted = 0;
    for (int k = 0; k < 7; k++) begin
      @(posedge clk_i); #1 in_valid = 5'b01000; put(3, 16'h1030 + 16'(k));
      @(negedge clk_i); if (in_ready[3]) accepted++;
    end
    chk(accepted == 4, "R9 queue depth", accepted, 4);
    chk(in_ready[3] == 1'b0, "R9 full blocks input", in_ready, 0);
    held = out_data[47:32];
    @(posedge clk_i); #1 in_valid = 5'b00100; put(2, 16'h1120);
    @(negedge clk_i);
    chk(out_valid[2] && out_data[47:32] == held, "R10 stalled output holds", out_data[47:32], held);
    chk(in_ready[2] == 1'b0, "R4 broadcast waits on full target", in_ready, 0);
    @(posedge clk_i); #1;
    @(negedge clk_i);
    chk(out_valid[1] == 1'b0, "R4 no partial broadcast", out_valid, 0);
    @(posedge clk_i); #1 out_ready = '1;
    seen = 1'b0;
    for (int k = 0; k < 8 && !seen; k++) begin
      @(negedge clk_i);
      if (in_ready[2]) seen = 1'b1;
      else @(posedge clk_i);
    end
    chk(seen, "R4 broadcast released", seen, 1);
    @(posedge clk_i); #1 in_valid = '0;
    @(negedge clk_i); chk(out_valid[1] == 1'b1, "R4 broadcast delivered", out_valid, 5'b00010);

    repeat (10) @(posedge clk_i);
    @(negedge clk_i);
    chk(out_valid == 5'b0, "R2 all queues drained", out_valid, 0);
    for (int o = 0; o < 5; o++)
      chk(exp_q[o].size() == 0, "R2 no lost words", exp_q[o].size(), 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
    $finish;
  end
endmodule